// File: doc/BRIEF.md
# Burst ROM Bus Cycle Sequencer

This block drives the external strobes for one memory region that holds burst-capable read-only memory. When the processor reads the region, the block runs one full-length access first. That access can be stretched by a programmed number of wait clocks and by an external wait pin. It then runs a fixed number of short burst beats. Each beat bumps the low address bits and wraps inside the burst-aligned block. Chip select is held low for the whole sequence, and so is the read strobe.

Any other access uses the plain single-beat cycle: a read from another bus master, or a write. That cycle honours extension clocks before and after the access, and the late read-strobe release setting. For a processor burst read, only the leading extension is honoured. The trailing extension and the late-release setting have no effect, and burst beats never take wait clocks.

A one-clock data-valid strobe marks the clock at whose closing edge read data is captured. A one-clock done pulse follows the last busy clock.

Top module: `brom_seq`

## Requirements
- R1: While reset is asserted and after it is released, cs_n_o and rd_n_o are 1, and valid_o and done_o are 0.
- R2: A request seen in an idle clock starts an access. Its full access is one lead clock, then `wait_cnt_i` wait clocks, then one capture clock in which valid_o is 1.
- R3: With `wait_pin_en_i` = 1 and `wait_cnt_i` >= 1, `wait_pin_i` is sampled at the edge that closes the last programmed wait clock. Each sample of 1 adds one further wait clock. When the enable is 0 or `wait_cnt_i` is 0, the pin has no effect.
- R4: For `kind_i` = 2'b00 (processor read), BEATS-1 burst beats follow the capture clock. Each beat is 1 clock, or 2 clocks when `burst_two_clk_i` = 1. No wait clocks are added and the wait pin is ignored.
- R5: valid_o pulses once per beat, in the last clock of the beat. At beat i, addr_o keeps the upper bits of `addr_i`. Its low log2(BEATS) bits equal (addr_i + i) mod BEATS.
- R6: cs_n_o stays 0 from the first busy clock through the last, with no gap between beats.
- R7: For a processor read, rd_n_o is 0 from the lead clock through the last beat. `rd_late_neg_i` has no effect.
- R8: With `ext_pre_en_i` = 1, any access begins with one clock in which cs_n_o is 0 and rd_n_o is 1.
- R9: With `ext_post_en_i` = 1, a non-processor access ends with one extra clock of cs_n_o = 0 and rd_n_o = 1. For a processor read, this input has no effect.
- R10: For `kind_i` = 2'b01 (other-master read), one beat is transferred. With `rd_late_neg_i` = 1, rd_n_o stays 0 for one extra clock after the capture clock, before any trailing extension.
- R11: For `kind_i` = 2'b10 or 2'b11 (write), rd_n_o stays 1 and valid_o stays 0 throughout.
- R12: done_o is 1 for exactly the one clock after the last busy clock. A request raised while an access is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken in an idle clock |
| kind_i | input | 2 | 00 processor read, 01 other read, 1x write |
| addr_i | input | AW | Start address |
| wait_cnt_i | input | WW | Programmed wait clocks for the full access |
| wait_pin_en_i | input | 1 | Enables the external wait pin |
| wait_pin_i | input | 1 | External wait request, active high |
| ext_pre_en_i | input | 1 | Leading chip-select extension enable |
| ext_post_en_i | input | 1 | Trailing chip-select extension enable |
| rd_late_neg_i | input | 1 | Late read-strobe release for basic reads |
| burst_two_clk_i | input | 1 | Burst beat lasts two clocks instead of one |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| addr_o | output | AW | Current beat address |
| valid_o | output | 1 | Read data capture strobe |
| done_o | output | 1 | One-clock end-of-access pulse |

## Verification
The bound properties rely on reset being applied before the first request and on BEATS being a power of two. They also rely on the start address, the access kind and the configuration inputs staying steady across each access. The bench changes every input half a clock away from the capture edge and raises requests only while the block is idle, except for one deliberate request during a busy access. It drives the wait pin high for the whole access except at the edge where a release is intended, so any sampling outside the last programmed wait clock shows up as extra busy clocks.

// File: rtl/brom_pkg.sv
package brom_pkg;

    localparam logic [1:0] KIND_CPU_RD   = 2'b00;
    localparam logic [1:0] KIND_OTHER_RD = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_LEAD  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_CAPT  = 3'd4,
        ST_HOLD  = 3'd5,
        ST_BURST = 3'd6,
        ST_POST  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/brom_wait_timer.sv
module brom_wait_timer #(
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [WW-1:0] load_val_i,
    input  logic          run_i,
    input  logic          pin_en_i,
    input  logic          pin_i,
    output logic          none_o,
    output logic          last_o
);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic hold;

    assign hold = pin_en_i && pin_i;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (run_i && (tmr_q.cnt != '0)) begin
            if (!((tmr_q.cnt == WW'(1)) && hold)) begin
                tmr_d.cnt = tmr_q.cnt - WW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign none_o = (tmr_q.cnt == '0);
    assign last_o = (tmr_q.cnt == WW'(1)) && !hold;

endmodule

// File: rtl/brom_beat_addr.sv
module brom_beat_addr #(
    parameter int AW    = 16,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);

    localparam int LB = $clog2(BEATS);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [LB-1:0] beat;
    } ba_t;

    ba_t ba_d, ba_q;

    always_comb begin
        ba_d = ba_q;
        if (load_i) begin
            ba_d.addr = addr_i;
            ba_d.beat = '0;
        end else if (step_i) begin
            ba_d.addr = {ba_q.addr[AW-1:LB], ba_q.addr[LB-1:0] + LB'(1)};
            ba_d.beat = ba_q.beat + LB'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ba_q <= '0;
        end else begin
            ba_q <= ba_d;
        end
    end

    assign addr_o = ba_q.addr;
    assign last_o = (ba_q.beat == LB'(BEATS - 1));

endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl
    import brom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] kind_i,
    input  logic       pre_i,
    input  logic       post_i,
    input  logic       late_i,
    input  logic       len2_i,
    input  logic       pin_en_i,
    input  logic       wait_none_i,
    input  logic       wait_last_i,
    input  logic       beat_last_i,
    output logic       load_o,
    output logic       step_o,
    output logic       run_wait_o,
    output logic       pin_en_o,
    output logic       cs_n_o,
    output logic       rd_n_o,
    output logic       valid_o,
    output logic       done_o
);

    typedef struct packed {
        seq_state_e st;
        logic [1:0] kind;
        logic       post;
        logic       late;
        logic       len2;
        logic       pin_en;
        logic       phase;
        logic       cs_n;
        logic       rd_n;
        logic       valid;
        logic       done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic is_read_d;
    logic strobe_state_d;

    always_comb begin
        ctl_d  = ctl_q;
        load_o = 1'b0;
        step_o = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.kind   = kind_i;
                    ctl_d.post   = post_i;
                    ctl_d.late   = late_i;
                    ctl_d.len2   = len2_i;
                    ctl_d.pin_en = pin_en_i;
                    ctl_d.phase  = 1'b0;
                    load_o       = 1'b1;
                    ctl_d.st     = pre_i ? ST_PRE : ST_LEAD;
                end
            end
            ST_PRE: begin
                ctl_d.st = ST_LEAD;
            end
            ST_LEAD: begin
                ctl_d.st = wait_none_i ? ST_CAPT : ST_WAIT;
            end
            ST_WAIT: begin
                if (wait_last_i) begin
                    ctl_d.st = ST_CAPT;
                end
            end
            ST_CAPT: begin
                if (ctl_q.kind == KIND_CPU_RD) begin
                    step_o      = 1'b1;
                    ctl_d.phase = 1'b0;
                    ctl_d.st    = ST_BURST;
                end else if ((ctl_q.kind == KIND_OTHER_RD) && ctl_q.late) begin
                    ctl_d.st = ST_HOLD;
                end else if (ctl_q.post) begin
                    ctl_d.st = ST_POST;
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                ctl_d.st = ctl_q.post ? ST_POST : ST_IDLE;
            end
            ST_BURST: begin
                if (ctl_q.len2 && !ctl_q.phase) begin
                    ctl_d.phase = 1'b1;
                end else begin
                    ctl_d.phase = 1'b0;
                    if (beat_last_i) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        step_o = 1'b1;
                    end
                end
            end
            ST_POST: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase

        is_read_d      = !ctl_d.kind[1];
        strobe_state_d = (ctl_d.st == ST_LEAD) || (ctl_d.st == ST_WAIT) ||
                         (ctl_d.st == ST_CAPT) || (ctl_d.st == ST_HOLD) ||
                         (ctl_d.st == ST_BURST);

        ctl_d.done  = (ctl_d.st == ST_IDLE) && (ctl_q.st != ST_IDLE);
        ctl_d.cs_n  = (ctl_d.st == ST_IDLE);
        ctl_d.rd_n  = !(is_read_d && strobe_state_d);
        ctl_d.valid = is_read_d &&
                      ((ctl_d.st == ST_CAPT) ||
                       ((ctl_d.st == ST_BURST) && (!ctl_d.len2 || ctl_d.phase)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.cs_n <= 1'b1;
            ctl_q.rd_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run_wait_o = (ctl_q.st == ST_WAIT);
    assign pin_en_o   = ctl_q.pin_en;
    assign cs_n_o     = ctl_q.cs_n;
    assign rd_n_o     = ctl_q.rd_n;
    assign valid_o    = ctl_q.valid;
    assign done_o     = ctl_q.done;

endmodule

// File: rtl/brom_seq.sv
module brom_seq #(
    parameter int AW    = 16,
    parameter int WW    = 3,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [WW-1:0] wait_cnt_i,
    input  logic          wait_pin_en_i,
    input  logic          wait_pin_i,
    input  logic          ext_pre_en_i,
    input  logic          ext_post_en_i,
    input  logic          rd_late_neg_i,
    input  logic          burst_two_clk_i,
    output logic          cs_n_o,
    output logic          rd_n_o,
    output logic [AW-1:0] addr_o,
    output logic          valid_o,
    output logic          done_o
);

    logic load;
    logic step;
    logic run_wait;
    logic pin_en;
    logic wait_none;
    logic wait_last;
    logic beat_last;

    brom_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .kind_i      (kind_i),
        .pre_i       (ext_pre_en_i),
        .post_i      (ext_post_en_i),
        .late_i      (rd_late_neg_i),
        .len2_i      (burst_two_clk_i),
        .pin_en_i    (wait_pin_en_i),
        .wait_none_i (wait_none),
        .wait_last_i (wait_last),
        .beat_last_i (beat_last),
        .load_o      (load),
        .step_o      (step),
        .run_wait_o  (run_wait),
        .pin_en_o    (pin_en),
        .cs_n_o      (cs_n_o),
        .rd_n_o      (rd_n_o),
        .valid_o     (valid_o),
        .done_o      (done_o)
    );

    brom_wait_timer #(.WW(WW)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (wait_cnt_i),
        .run_i      (run_wait),
        .pin_en_i   (pin_en),
        .pin_i      (wait_pin_i),
        .none_o     (wait_none),
        .last_o     (wait_last)
    );

    brom_beat_addr #(.AW(AW), .BEATS(BEATS)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .addr_i (addr_i),
        .step_i (step),
        .addr_o (addr_o),
        .last_o (beat_last)
    );

endmodule

// File: rtl/brom_seq_chk.sv
module brom_seq_chk #(
    parameter int AW    = 16,
    parameter int BEATS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n_o,
    input logic          rd_n_o,
    input logic [AW-1:0] addr_o,
    input logic          valid_o,
    input logic          done_o
);

    localparam int LB = $clog2(BEATS);

    assert_rd_within_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o);

    assert_valid_under_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!cs_n_o && !rd_n_o));

    assert_done_while_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !valid_o));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_cs_release_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> done_o);

    assert_beat_low_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (addr_o[LB-1:0] == $past(addr_o[LB-1:0]) + LB'(1)));

    assert_beat_high_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> $stable(addr_o[AW-1:LB]));

endmodule

bind brom_seq brom_seq_chk #(.AW(AW), .BEATS(BEATS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_o  (cs_n_o),
    .rd_n_o  (rd_n_o),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .done_o  (done_o)
);

// File: tb/brom_seq_test.sv
`timescale 1ns/1ps
module brom_seq_test;

    localparam int AW = 16;
    localparam int WW = 3;
    localparam int BEATS = 4;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [2:0]  w;
        logic        pe;
        logic [2:0]  x;
        logic        pre;
        logic        post;
        logic        late;
        logic        len2;
        logic [4:0]  ecs;
        logic [4:0]  erd;
        logic [3:0]  evl;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'h1230, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5,  5'd5,  4'd4},
        '{2'b00, 16'h00A6, 3'd2, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd8,  5'd7,  4'd4},
        '{2'b00, 16'h4FFF, 3'd1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd12, 5'd12, 4'd4},
        '{2'b00, 16'h0001, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 5'd8,  5'd8,  4'd4},
        '{2'b00, 16'h8003, 3'd3, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd9,  5'd8,  4'd4},
        '{2'b01, 16'h0102, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  5'd2,  4'd1},
        '{2'b01, 16'h0203, 3'd1, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd7,  5'd5,  4'd1},
        '{2'b01, 16'h0304, 3'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5,  5'd4,  4'd1},
        '{2'b10, 16'h0405, 3'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd5,  5'd0,  4'd0},
        '{2'b11, 16'h0506, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  5'd0,  4'd0},
        '{2'b00, 16'h7FF2, 3'd2, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7,  5'd7,  4'd4},
        '{2'b01, 16'h0607, 3'd1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5,  5'd5,  4'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [1:0]    kind_i = 2'b00;
    logic [AW-1:0] addr_i = '0;
    logic [WW-1:0] wait_cnt_i = '0;
    logic          wait_pin_en_i = 1'b0;
    logic          wait_pin_i = 1'b0;
    logic          ext_pre_en_i = 1'b0;
    logic          ext_post_en_i = 1'b0;
    logic          rd_late_neg_i = 1'b0;
    logic          burst_two_clk_i = 1'b0;
    logic          cs_n_o;
    logic          rd_n_o;
    logic [AW-1:0] addr_o;
    logic          valid_o;
    logic          done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    brom_seq #(.AW(AW), .WW(WW), .BEATS(BEATS)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .kind_i          (kind_i),
        .addr_i          (addr_i),
        .wait_cnt_i      (wait_cnt_i),
        .wait_pin_en_i   (wait_pin_en_i),
        .wait_pin_i      (wait_pin_i),
        .ext_pre_en_i    (ext_pre_en_i),
        .ext_post_en_i   (ext_post_en_i),
        .rd_late_neg_i   (rd_late_neg_i),
        .burst_two_clk_i (burst_two_clk_i),
        .cs_n_o          (cs_n_o),
        .rd_n_o          (rd_n_o),
        .addr_o          (addr_o),
        .valid_o         (valid_o),
        .done_o          (done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int i);
        logic [AW-1:0] m;
        m = AW'(BEATS - 1);
        return (a & ~m) | ((a + AW'(i)) & m);
    endfunction

    task automatic run_vec(input vec_t v, input int poke);
        int k = 0;
        int rdc = 0;
        int vc = 0;
        int first_v = 0;
        int first_rd = 0;
        int gap = 0;
        int addr_bad = 0;
        int loops = 0;
        int xe;
        int target;
        bit fin = 1'b0;
        xe = (v.pe && (v.w != 0)) ? int'(v.x) : 0;
        target = int'(v.pre) + 1 + int'(v.w) + int'(v.x);
        @(negedge clk);
        kind_i = v.kind;
        addr_i = v.addr;
        wait_cnt_i = v.w;
        wait_pin_en_i = v.pe;
        ext_pre_en_i = v.pre;
        ext_post_en_i = v.post;
        rd_late_neg_i = v.late;
        burst_two_clk_i = v.len2;
        wait_pin_i = 1'b1;
        req_i = 1'b1;
        while (!fin) begin
            @(negedge clk);
            loops++;
            if (loops == 1) req_i = 1'b0;
            if (done_o) begin
                fin = 1'b1;
            end else begin
                if (!cs_n_o) k++;
                else gap++;
                if (!rd_n_o) begin
                    rdc++;
                    if (first_rd == 0) first_rd = k;
                end
                if (valid_o) begin
                    if (first_v == 0) first_v = k;
                    if (addr_o != beat_addr(v.addr, vc)) begin
                        addr_bad++;
                        $display("FAIL R5 beat %0d address actual=%0h expected=%0h",
                                 vc, addr_o, beat_addr(v.addr, vc));
                    end
                    vc++;
                end
                wait_pin_i = (k != target);
                if (poke != 0 && k == poke) begin
                    req_i = 1'b1;
                    kind_i = 2'b10;
                end else if (poke != 0 && k == poke + 1) begin
                    req_i = 1'b0;
                    kind_i = v.kind;
                end
            end
            if (loops > 100 && !fin) begin
                chk(1'b0, "R12 access never ended", loops, int'(v.ecs));
                fin = 1'b1;
            end
        end
        wait_pin_i = 1'b0;
        req_i = 1'b0;
        chk(k == int'(v.ecs), "R2 R4 R8 R9 cs-low clocks", k, int'(v.ecs));
        chk(rdc == int'(v.erd), "R7 R10 R11 rd-low clocks", rdc, int'(v.erd));
        chk(vc == int'(v.evl), "R5 R11 valid pulses", vc, int'(v.evl));
        chk(gap == 0, "R6 cs high inside access", gap, 0);
        chk(addr_bad == 0, "R5 beat address mismatches", addr_bad, 0);
        if (v.evl != 0)
            chk(first_v == int'(v.pre) + 2 + int'(v.w) + xe, "R2 R3 first valid clock",
                first_v, int'(v.pre) + 2 + int'(v.w) + xe);
        if (!v.kind[1])
            chk(first_rd == int'(v.pre) + 1, "R8 first rd-low clock", first_rd, int'(v.pre) + 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R12 done lasts one clock", int'(done_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o && rd_n_o && !valid_o && !done_o, "R1 outputs in reset",
            {cs_n_o, rd_n_o, valid_o, done_o}, 4'b1100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o && rd_n_o && !valid_o && !done_o, "R1 outputs after reset",
            {cs_n_o, rd_n_o, valid_o, done_o}, 4'b1100);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 0);
        end

        // R12: a request raised mid-access is not taken
        run_vec(VECS[0], 2);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(cs_n_o == 1'b1, "R12 busy request ignored", int'(cs_n_o), 1);
        end

        // R1: reset in the middle of a burst returns outputs to idle
        @(negedge clk);
        kind_i = 2'b00;
        addr_i = 16'h2222;
        wait_cnt_i = '0;
        wait_pin_en_i = 1'b0;
        ext_pre_en_i = 1'b0;
        ext_post_en_i = 1'b0;
        burst_two_clk_i = 1'b1;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b0, "R6 access running before reset", int'(cs_n_o), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n_o && rd_n_o && !valid_o && !done_o, "R1 outputs on mid-access reset",
            {cs_n_o, rd_n_o, valid_o, done_o}, 4'b1100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 idle after reset release", int'(cs_n_o), 1);
        run_vec(VECS[2], 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule